// File: doc/BRIEF.md
# Doorbell Mailbox Channel Window

This block is one doorbell channel window shared between a sending agent and a receiving agent. It holds a vector of independent doorbell flags. The sender rings flags by writing ones, and it polls the same flag vector to learn when a transfer has been consumed. A flag that reads back as 0 means its transfer is complete.

The receiver sees both the raw flags and a pending view filtered by its own per-flag mask. It retires a serviced flag by writing a one to the clear register. Retiring a flag that was actually set raises a transfer-acknowledge status bit on the sender side. That bit has its own clear register and its own enable register.

Each side has a simple register slave port and one window interrupt output. A combine-enable control bit on each side gates whether that interrupt reaches the interrupt aggregator.

Top module: `doorbell_window`

## Requirements
- R1: After reset all flags are 0, every receiver mask bit is 1, and the acknowledge status, acknowledge enable and both combine-enable bits are 0. Both interrupts are therefore 0.
- R2: A sender write to address 1 ORs the written bits into the flag vector. The flag vector reads back on sender address 0 and on receiver address 0 from the cycle after the write.
- R3: A receiver write to address 2 clears the written flag bits. When a sender ring and a receiver clear hit the same flag in the same cycle, the flag ends up 0.
- R4: A receiver clear that hits at least one flag that was 1 sets the acknowledge status, which reads on sender address 2 bit 0. A clear that hits only flags that were 0 leaves the status unchanged.
- R5: Writing 1 to bit 0 of sender address 3 clears the acknowledge status. If a new acknowledge event occurs in the same cycle, the status stays 1.
- R6: Writing ones to receiver address 4 sets mask bits, and writing ones to receiver address 5 clears them. The mask reads on receiver address 3. The pending view on receiver address 1 equals the flags AND NOT the mask.
- R7: The receiver interrupt is 1 exactly when the pending view is nonzero and the receiver combine enable is 1. The combine enable is bit 0 of receiver address 6 and can be read back there.
- R8: The sender interrupt is 1 exactly when the acknowledge status, the acknowledge enable and the sender combine enable are all 1. The acknowledge enable is bit 0 of sender address 4, and the combine enable is bit 0 of sender address 5. Both can be read back.
- R9: Reads of write-only or unused addresses return 0. These are sender addresses 1, 3, 6 and 7, and receiver addresses 2, 4, 5 and 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| snd_we | input | 1 | Sender write strobe |
| snd_waddr | input | 3 | Sender write word address |
| snd_wdata | input | NUM_FLAGS | Sender write data |
| snd_raddr | input | 3 | Sender read word address |
| snd_rdata | output | NUM_FLAGS | Sender read data (combinational) |
| snd_irq | output | 1 | Sender window interrupt |
| rcv_we | input | 1 | Receiver write strobe |
| rcv_waddr | input | 3 | Receiver write word address |
| rcv_wdata | input | NUM_FLAGS | Receiver write data |
| rcv_raddr | input | 3 | Receiver read word address |
| rcv_rdata | output | NUM_FLAGS | Receiver read data (combinational) |
| rcv_irq | output | 1 | Receiver window interrupt |

## Verification
Every register on both sides is read after every clock. A wrong flag, mask or acknowledge state therefore shows at the ports in the first cycle after the write that corrupted it. It appears as a mismatched readback or a wrong interrupt level. A lost clear-over-set priority shows as a flag that stays 1 after a colliding write. A spurious or missing acknowledge shows at once on sender address 2 and on the sender interrupt.

// File: rtl/db_pkg.sv
package db_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    S_FLAGS   = 3'd0,
    S_RING    = 3'd1,
    S_ACK_ST  = 3'd2,
    S_ACK_CLR = 3'd3,
    S_ACK_EN  = 3'd4,
    S_CTRL    = 3'd5
  } snd_reg_e;

  typedef enum logic [ADDR_W-1:0] {
    R_FLAGS = 3'd0,
    R_PEND  = 3'd1,
    R_CLR   = 3'd2,
    R_MASK  = 3'd3,
    R_MSET  = 3'd4,
    R_MCLR  = 3'd5,
    R_CTRL  = 3'd6
  } rcv_reg_e;
endpackage

// File: rtl/db_flag_store.sv
module db_flag_store #(
  parameter int NUM_FLAGS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] ring_bits,
  input  logic [NUM_FLAGS-1:0] clr_bits,
  output logic [NUM_FLAGS-1:0] flags,
  output logic                 ack_evt
);
  // a clear retires a transfer only where the flag was really set
  function automatic logic ack_hit(input logic [NUM_FLAGS-1:0] cur,
                                   input logic [NUM_FLAGS-1:0] clr);
    return |(cur & clr);
  endfunction

  assign ack_evt = ack_hit(flags, clr_bits);

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           bit_q <= 1'b0;
      else if (clr_bits[i]) bit_q <= 1'b0;   // clear has priority
      else if (ring_bits[i]) bit_q <= 1'b1;
    end
    assign flags[i] = bit_q;
  end

  assert_clear_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_bits) |=> ((flags & $past(clr_bits)) == '0));

  assert_ring_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ring_bits & ~clr_bits)) |=>
      ((flags & $past(ring_bits & ~clr_bits)) == $past(ring_bits & ~clr_bits)));
endmodule

// File: rtl/db_sender_side.sv
module db_sender_side
  import db_pkg::*;
#(
  parameter int NUM_FLAGS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [ADDR_W-1:0]    waddr,
  input  logic [NUM_FLAGS-1:0] wdata,
  input  logic [ADDR_W-1:0]    raddr,
  input  logic [NUM_FLAGS-1:0] flags,
  input  logic                 ack_evt,
  output logic [NUM_FLAGS-1:0] rdata,
  output logic [NUM_FLAGS-1:0] ring_bits,
  output logic                 irq
);
  localparam logic [NUM_FLAGS-1:0] ZERO = '0;

  logic ack_st, ack_en, comb_en;
  logic wr_ring, wr_ack_clr, wr_ack_en, wr_ctrl;

  function automatic logic [NUM_FLAGS-1:0] bit0_word(input logic b);
    return {{(NUM_FLAGS-1){1'b0}}, b};
  endfunction

  assign wr_ring    = we && (waddr == S_RING);
  assign wr_ack_clr = we && (waddr == S_ACK_CLR) && wdata[0];
  assign wr_ack_en  = we && (waddr == S_ACK_EN);
  assign wr_ctrl    = we && (waddr == S_CTRL);
  assign ring_bits  = wr_ring ? wdata : ZERO;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_st  <= 1'b0;
      ack_en  <= 1'b0;
      comb_en <= 1'b0;
    end else begin
      if (ack_evt)         ack_st <= 1'b1;   // new event beats a clear
      else if (wr_ack_clr) ack_st <= 1'b0;
      if (wr_ack_en) ack_en  <= wdata[0];
      if (wr_ctrl)   comb_en <= wdata[0];
    end
  end

  assign irq = ack_st & ack_en & comb_en;

  always_comb begin
    case (raddr)
      S_FLAGS:  rdata = flags;
      S_ACK_ST: rdata = bit0_word(ack_st);
      S_ACK_EN: rdata = bit0_word(ack_en);
      S_CTRL:   rdata = bit0_word(comb_en);
      default:  rdata = ZERO;
    endcase
  end

  assert_ack_evt_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_evt |=> ack_st);

  assert_ack_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_st) |-> $past(ack_evt));

  assert_ack_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ack_clr && !ack_evt) |=> !ack_st);

  assert_snd_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ack_en && comb_en));
endmodule

// File: rtl/db_receiver_side.sv
module db_receiver_side
  import db_pkg::*;
#(
  parameter int NUM_FLAGS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [ADDR_W-1:0]    waddr,
  input  logic [NUM_FLAGS-1:0] wdata,
  input  logic [ADDR_W-1:0]    raddr,
  input  logic [NUM_FLAGS-1:0] flags,
  output logic [NUM_FLAGS-1:0] rdata,
  output logic [NUM_FLAGS-1:0] clr_bits,
  output logic                 irq
);
  localparam logic [NUM_FLAGS-1:0] ZERO = '0;

  logic [NUM_FLAGS-1:0] mask, pending;
  logic comb_en;
  logic wr_mset, wr_mclr, wr_ctrl;

  function automatic logic [NUM_FLAGS-1:0] filter(input logic [NUM_FLAGS-1:0] f,
                                                  input logic [NUM_FLAGS-1:0] m);
    return f & ~m;
  endfunction

  assign wr_mset  = we && (waddr == R_MSET);
  assign wr_mclr  = we && (waddr == R_MCLR);
  assign wr_ctrl  = we && (waddr == R_CTRL);
  assign clr_bits = (we && (waddr == R_CLR)) ? wdata : ZERO;
  assign pending  = filter(flags, mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask    <= '1;
      comb_en <= 1'b0;
    end else begin
      if (wr_mset) mask <= mask | wdata;
      if (wr_mclr) mask <= mask & ~wdata;
      if (wr_ctrl) comb_en <= wdata[0];
    end
  end

  assign irq = comb_en && (pending != ZERO);

  always_comb begin
    case (raddr)
      R_FLAGS: rdata = flags;
      R_PEND:  rdata = pending;
      R_MASK:  rdata = mask;
      R_CTRL:  rdata = {{(NUM_FLAGS-1){1'b0}}, comb_en};
      default: rdata = ZERO;
    endcase
  end

  assert_mask_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mset |=> ((mask & $past(wdata)) == $past(wdata)));

  assert_mask_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mclr |=> ((mask & $past(wdata)) == ZERO));

  assert_rcv_irq_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (comb_en && (flags != ZERO)));
endmodule

// File: rtl/doorbell_window.sv
module doorbell_window
  import db_pkg::*;
#(
  parameter int NUM_FLAGS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 snd_we,
  input  logic [ADDR_W-1:0]    snd_waddr,
  input  logic [NUM_FLAGS-1:0] snd_wdata,
  input  logic [ADDR_W-1:0]    snd_raddr,
  output logic [NUM_FLAGS-1:0] snd_rdata,
  output logic                 snd_irq,
  input  logic                 rcv_we,
  input  logic [ADDR_W-1:0]    rcv_waddr,
  input  logic [NUM_FLAGS-1:0] rcv_wdata,
  input  logic [ADDR_W-1:0]    rcv_raddr,
  output logic [NUM_FLAGS-1:0] rcv_rdata,
  output logic                 rcv_irq
);
  logic [NUM_FLAGS-1:0] flags, ring_bits, clr_bits;
  logic                 ack_evt;

  db_flag_store #(.NUM_FLAGS(NUM_FLAGS)) u_store (
    .clk(clk), .rst_n(rst_n), .ring_bits(ring_bits), .clr_bits(clr_bits),
    .flags(flags), .ack_evt(ack_evt)
  );

  db_sender_side #(.NUM_FLAGS(NUM_FLAGS)) u_snd (
    .clk(clk), .rst_n(rst_n), .we(snd_we), .waddr(snd_waddr),
    .wdata(snd_wdata), .raddr(snd_raddr), .flags(flags), .ack_evt(ack_evt),
    .rdata(snd_rdata), .ring_bits(ring_bits), .irq(snd_irq)
  );

  db_receiver_side #(.NUM_FLAGS(NUM_FLAGS)) u_rcv (
    .clk(clk), .rst_n(rst_n), .we(rcv_we), .waddr(rcv_waddr),
    .wdata(rcv_wdata), .raddr(rcv_raddr), .flags(flags),
    .rdata(rcv_rdata), .clr_bits(clr_bits), .irq(rcv_irq)
  );
endmodule

// File: tb/sim_doorbell_window.sv
module sim_doorbell_window;
  localparam int CLK_PERIOD = 40;
  localparam int NF = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic snd_we = 1'b0, rcv_we = 1'b0;
  logic [2:0] snd_waddr = '0, snd_raddr = '0, rcv_waddr = '0, rcv_raddr = '0;
  logic [NF-1:0] snd_wdata = '0, rcv_wdata = '0;
  logic [NF-1:0] snd_rdata, rcv_rdata;
  logic snd_irq, rcv_irq;

  int checks = 0;
  int failures = 0;

  // behavioural reference state
  bit [NF-1:0] m_flags, m_mask;
  bit m_ack, m_en, m_scomb, m_rcomb;

  always #(CLK_PERIOD/2) clk = ~clk;

  doorbell_window #(.NUM_FLAGS(NF)) u0 (
    .clk(clk), .rst_n(rst_n),
    .snd_we(snd_we), .snd_waddr(snd_waddr), .snd_wdata(snd_wdata),
    .snd_raddr(snd_raddr), .snd_rdata(snd_rdata), .snd_irq(snd_irq),
    .rcv_we(rcv_we), .rcv_waddr(rcv_waddr), .rcv_wdata(rcv_wdata),
    .rcv_raddr(rcv_raddr), .rcv_rdata(rcv_rdata), .rcv_irq(rcv_irq)
  );

  function automatic bit [NF-1:0] exp_snd(int a);
    case (a)
      0: return m_flags;
      2: return {31'b0, m_ack};
      4: return {31'b0, m_en};
      5: return {31'b0, m_scomb};
      default: return '0;
    endcase
  endfunction

  function automatic bit [NF-1:0] exp_rcv(int a);
    case (a)
      0: return m_flags;
      1: return m_flags & ~m_mask;
      3: return m_mask;
      6: return {31'b0, m_rcomb};
      default: return '0;
    endcase
  endfunction

  function automatic string tag_snd(int a);
    case (a)
      0: return "R2";
      2: return "R4";
      4, 5: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic string tag_rcv(int a);
    case (a)
      0: return "R3";
      1, 3: return "R6";
      6: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string req, string what, logic [NF-1:0] act, logic [NF-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(string force_tag);
    bit e_sirq, e_rirq;
    e_sirq = m_ack && m_en && m_scomb;
    e_rirq = m_rcomb && ((m_flags & ~m_mask) != 0);
    check(force_tag == "" ? "R8" : force_tag, "snd_irq", {31'b0, snd_irq}, {31'b0, e_sirq});
    check(force_tag == "" ? "R7" : force_tag, "rcv_irq", {31'b0, rcv_irq}, {31'b0, e_rirq});
    for (int a = 0; a < 8; a++) begin
      snd_raddr = a[2:0];
      rcv_raddr = a[2:0];
      #1;
      check(force_tag == "" ? tag_snd(a) : force_tag, $sformatf("snd_rd[%0d]", a), snd_rdata, exp_snd(a));
      check(force_tag == "" ? tag_rcv(a) : force_tag, $sformatf("rcv_rd[%0d]", a), rcv_rdata, exp_rcv(a));
    end
  endtask

  // one clock with optional writes on both sides, then full comparison
  task automatic cyc(bit swe, int sa, bit [NF-1:0] sd, bit rwe, int ra, bit [NF-1:0] rd);
    bit [NF-1:0] set_b, clr_b;
    bit hit;
    snd_we = swe; snd_waddr = sa[2:0]; snd_wdata = sd;
    rcv_we = rwe; rcv_waddr = ra[2:0]; rcv_wdata = rd;
    set_b = (swe && sa == 1) ? sd : '0;
    clr_b = (rwe && ra == 2) ? rd : '0;
    hit = (clr_b & m_flags) != 0;
    @(posedge clk);
    m_flags = (m_flags | set_b) & ~clr_b;
    if (hit) m_ack = 1'b1;
    else if (swe && sa == 3 && sd[0]) m_ack = 1'b0;
    if (swe && sa == 4) m_en = sd[0];
    if (swe && sa == 5) m_scomb = sd[0];
    if (rwe && ra == 4) m_mask = m_mask | rd;
    if (rwe && ra == 5) m_mask = m_mask & ~rd;
    if (rwe && ra == 6) m_rcomb = rd[0];
    #2;
    snd_we = 1'b0; rcv_we = 1'b0;
    compare_all("");
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    m_flags = '0; m_mask = '1; m_ack = 0; m_en = 0; m_scomb = 0; m_rcomb = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    compare_all("R1");                                  // R1 reset state
    cyc(0, 0, 0, 0, 0, 0);
    // R2: rings accumulate
    cyc(1, 1, 32'h0000_00F1, 0, 0, 0);
    cyc(1, 1, 32'h8000_0000, 0, 0, 0);
    // R6: unmask bits 0 and 31 (bit 4 stays masked)
    cyc(0, 0, 0, 1, 5, 32'h8000_0001);
    // R7: combine enable on receiver
    cyc(0, 0, 0, 1, 6, 32'h1);
    // R8: sender enables
    cyc(1, 4, 32'h1, 0, 0, 0);
    cyc(1, 5, 32'h1, 0, 0, 0);
    // R4: clearing an idle flag gives no acknowledge
    cyc(0, 0, 0, 1, 2, 32'h0000_0100);
    // R4: clearing a set flag raises acknowledge and sender irq
    cyc(0, 0, 0, 1, 2, 32'h0000_0001);
    // R5: acknowledge clear collides with new event, status stays
    cyc(1, 3, 32'h1, 1, 2, 32'h8000_0000);
    // R5: plain acknowledge clear
    cyc(1, 3, 32'h1, 0, 0, 0);
    // R3: ring and clear the same idle flag, clear wins, no acknowledge
    cyc(1, 1, 32'h0000_0002, 1, 2, 32'h0000_0002);
    // R6: mask everything again, then pending view empties
    cyc(1, 1, 32'h0000_0300, 1, 4, 32'hFFFF_FFFF);
    cyc(0, 0, 0, 1, 5, 32'h0000_0200);
    // R8: enable off hides the interrupt while status is set
    cyc(1, 4, 32'h0, 1, 2, 32'h0000_0200);
    cyc(1, 4, 32'h1, 0, 0, 0);
    // R7: receiver combine off
    cyc(0, 0, 0, 1, 6, 32'h0);
    // R9: writes to read-only addresses have no effect
    cyc(1, 0, 32'hFFFF_FFFF, 1, 0, 32'hFFFF_FFFF);
    cyc(1, 2, 32'h0, 1, 1, 32'hFFFF_FFFF);
    summary();
    $finish;
  end
endmodule